// File: doc/BRIEF.md
# Transmit Checksum Inserter

This block sits on the transmit byte stream ahead of the MAC. Each frame arrives as a run of bytes that ends with a last marker. A sideband offload bit is sampled with the first byte of the frame. When that bit is set, the first eight bytes are a control block rather than frame data. The block removes the control block. It reads from it the positions of the network-layer and transport-layer headers and the checksum options. It then fills in the IPv4 header checksum and the TCP or UDP checksum before the frame leaves.

Every frame is stored whole in an internal byte buffer before any byte is sent. The sums are built while the bytes arrive. The finished checksums are then substituted at their field positions as the buffer is read out. Frames without the offload bit leave exactly as they came in, and frames of both kinds may be interleaved in any order.

Top module: `txck_insert`

## Requirements
- R1: With the offload bit high on a frame's first byte, bytes 0..7 of that frame are a control block and are never output. Only the bytes that follow are sent, in order, with out_last on the final one. Control layout: byte 0 bit 0 = insert IP checksum, bit 1 = insert TCP/UDP checksum, bit 2 = UDP (0 = TCP), bit 3 = pseudo-header sum supplied. Byte 2 = IP header offset. Byte 3 = transport header offset. Bytes 6..7 = supplied pseudo-header sum, high byte first. Offsets count from the first data byte after the control block. Bytes 1, 4 and 5 are ignored.
- R2: A frame whose first byte has the offload bit low is output byte for byte unchanged, with the same length.
- R3: The offload bit is sampled only on a frame's first byte; its value on any later byte has no effect on the output.
- R4: When the IP bit is set, the two bytes at IP offset +10 and +11 are replaced, high byte first, by the ones' complement of the folded 16-bit ones'-complement sum of the IP header. That header has length 4 x (low nibble of its first byte), and its checksum field is taken as zero.
- R5: When the transport bit is set for TCP, the bytes at transport offset +16/+17 carry the ones' complement of the folded sum of two parts. The first part is the transport bytes from the transport offset up to IP offset + IP total length (bytes IP+2..IP+3), with the checksum field taken as zero and a trailing odd byte padded with zero. The second part is a pseudo-header: the words at IP+12..IP+19, the protocol byte at IP+9, and total length minus header length. Bytes past the IP total length are not summed.
- R6: For UDP the transport checksum is written at transport offset +6/+7 by the same rule. A result of 0x0000 is sent as 0xFFFF.
- R7: When the supplied-sum bit is set, the supplied 16-bit value replaces the derived pseudo-header sum in the transport checksum.
- R8: When the IP header marks a fragment (more-fragments flag, bit 5 of IP+6, or a nonzero fragment offset), no transport checksum is written and those bytes leave unchanged. The IP checksum is still written if requested.
- R9: After reset in_ready is high and out_valid low. No byte is output before the frame's last byte is accepted. in_ready stays low while a frame is being sent. Frames hold 1 to DEPTH data bytes.
- R10: While out_valid is high and out_ready low, out_data and out_last hold their values.
- R11: An offload frame whose control flags are all zero is output unchanged apart from the removed control block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block accepts an input byte |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Input byte is the last of the frame |
| in_offload | input | 1 | Offload enable, sampled on a frame's first byte |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream accepts an output byte |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Output byte is the last of the frame |

## Verification
The hardest case to reach from the ports is a UDP checksum that folds to zero, because it needs a payload tuned to a particular sum. The bench first builds a frame whose last payload word is zero and works out the checksum that frame would carry. It then writes that value into the last word, which drives the true sum to all ones and the complement to zero, so the 0xFFFF substitution must appear. Fragment marking, padding past the IP total length and the offload bit raised on later bytes are built into the directed frames in the same way.

// File: rtl/txck_pkg.sv
package txck_pkg;

    localparam int CTL_BYTES   = 8;
    localparam int IP_CS_REL   = 10;
    localparam int TCP_CS_REL  = 16;
    localparam int UDP_CS_REL  = 6;
    localparam int POS_W       = 17;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CTL,
        ST_BODY,
        ST_FIN,
        ST_SEND
    } state_e;

    typedef struct packed {
        logic        ip_en;
        logic        l4_en;
        logic        udp;
        logic        ph_given;
        logic [7:0]  l3_off;
        logic [7:0]  l4_off;
        logic [15:0] ph_sum;
    } ctl_t;

    // place a byte in the high or low lane of a 16-bit word
    function automatic logic [31:0] lane(input logic odd, input logic [7:0] b);
        return odd ? {24'd0, b} : {16'd0, b, 8'd0};
    endfunction

    // end-around carry fold of a 32-bit accumulator to 16 bits
    function automatic logic [15:0] fold16(input logic [31:0] s);
        logic [16:0] a;
        logic [15:0] b;
        a = {1'b0, s[15:0]} + {1'b0, s[31:16]};
        b = a[15:0] + {15'd0, a[16]};
        return b;
    endfunction

endpackage

// File: rtl/txck_ctl_parse.sv
module txck_ctl_parse
    import txck_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       wr,
    input  logic [2:0] idx,
    input  logic [7:0] din,
    output ctl_t       ctl
);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            ctl <= '0;
        end else if (wr) begin
            case (idx)
                3'd0: begin
                    ctl.ip_en    <= din[0];
                    ctl.l4_en    <= din[1];
                    ctl.udp      <= din[2];
                    ctl.ph_given <= din[3];
                end
                3'd2: ctl.l3_off        <= din;
                3'd3: ctl.l4_off        <= din;
                3'd6: ctl.ph_sum[15:8]  <= din;
                3'd7: ctl.ph_sum[7:0]   <= din;
                default: ;
            endcase
        end
    end

    // R11: a cleared control block stays cleared until a new block byte arrives
    p_ctl_idle_r11: assert property (@(posedge clk) disable iff (rst)
        (!wr && !clr && ctl == '0) |=> ctl == '0);

endmodule

// File: rtl/txck_sum_acc.sv
module txck_sum_acc
    import txck_pkg::*;
#(
    parameter int AW = 11
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          en,
    input  logic [AW-1:0] pos,
    input  logic [7:0]    din,
    input  logic [7:0]    l3_off,
    input  logic [7:0]    l4_off,
    input  logic          udp,
    input  logic          ph_given,
    output logic [31:0]   ip_acc,
    output logic [31:0]   l4_acc,
    output logic [5:0]    hlen,
    output logic [15:0]   totlen,
    output logic          frag
);

    logic [POS_W-1:0] p, b3, b4, r3, r4, lim, cs4;
    logic             at3, at4;
    logic [5:0]       hlen_now;
    logic             in_ip, ip_skip, in_l4, l4_skip, in_ph;
    logic [31:0]      ip_add, l4_add;

    always_comb begin
        p   = POS_W'(pos);
        b3  = POS_W'(l3_off);
        b4  = POS_W'(l4_off);
        at3 = (p >= b3);
        at4 = (p >= b4);
        r3  = p - b3;
        r4  = p - b4;
        lim = b3 + POS_W'(totlen);
        cs4 = udp ? POS_W'(UDP_CS_REL) : POS_W'(TCP_CS_REL);

        hlen_now = (at3 && r3 == '0) ? {din[3:0], 2'b00} : hlen;
        in_ip    = at3 && (r3 < POS_W'(hlen_now));
        ip_skip  = (r3 == POS_W'(IP_CS_REL)) || (r3 == POS_W'(IP_CS_REL + 1));
        in_l4    = at4 && (p < lim);
        l4_skip  = (r4 == cs4) || (r4 == cs4 + 1'b1);
        // pseudo-header: protocol byte and both addresses
        in_ph    = at3 && !ph_given &&
                   ((r3 == POS_W'(9)) || (r3 >= POS_W'(12) && r3 < POS_W'(20)));

        ip_add = (in_ip && !ip_skip) ? lane(r3[0], din) : 32'd0;
        l4_add = ((in_l4 && !l4_skip) ? lane(r4[0], din) : 32'd0)
               + (in_ph ? lane(r3[0], din) : 32'd0);
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            ip_acc <= '0;
            l4_acc <= '0;
            hlen   <= '0;
            totlen <= '0;
            frag   <= 1'b0;
        end else if (en) begin
            ip_acc <= ip_acc + ip_add;
            l4_acc <= l4_acc + l4_add;
            if (at3) begin
                case (r3)
                    POS_W'(0): hlen          <= {din[3:0], 2'b00};
                    POS_W'(2): totlen[15:8]  <= din;
                    POS_W'(3): totlen[7:0]   <= din;
                    POS_W'(6): frag          <= din[5] | (|din[4:0]);
                    POS_W'(7): frag          <= frag | (|din);
                    default: ;
                endcase
            end
        end
    end

    // R4: the IP checksum field bytes never change the header sum
    p_ip_field_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (en && !clr && at3 && ip_skip) |=> $stable(ip_acc));

    // R5: bytes beyond the IP total length never change the transport sum
    p_pad_ignored_r5: assert property (@(posedge clk) disable iff (rst)
        (en && !clr && at4 && !in_ph && p >= lim && totlen != 16'd0) |=> $stable(l4_acc));

endmodule

// File: rtl/txck_frame_buf.sv
module txck_frame_buf #(
    parameter int DEPTH = 2048,
    parameter int AW    = 11
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/txck_insert.sv
module txck_insert
    import txck_pkg::*;
#(
    parameter int DEPTH = 2048
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    output logic       in_ready,
    input  logic [7:0] in_data,
    input  logic       in_last,
    input  logic       in_offload,
    output logic       out_valid,
    input  logic       out_ready,
    output logic [7:0] out_data,
    output logic       out_last
);

    localparam int         AW  = $clog2(DEPTH);
    localparam logic [AW:0] CAP = (AW + 1)'(DEPTH);

    state_e        st;
    logic [2:0]    cidx;
    logic [AW:0]   wcnt, rcnt;
    logic          accept, ctl_wr, buf_wr, fr_done;
    logic [2:0]    ctl_idx;
    ctl_t          ctl;
    logic [31:0]   ip_acc, l4_acc, l4_all;
    logic [5:0]    hlen;
    logic [15:0]   totlen, l4_len, ip_cs_n, l4_raw, l4_cs_n;
    logic          frag;
    logic          ip_do, l4_do;
    logic [15:0]   ip_cs_q, l4_cs_q;
    logic [7:0]    rd_byte;
    logic [POS_W-1:0] rp, ip_pos, l4_pos;

    // ---------------- input side ----------------
    always_comb begin
        in_ready = (st == ST_IDLE || st == ST_CTL || st == ST_BODY) && (wcnt < CAP);
        accept   = in_valid && in_ready;
        ctl_wr   = accept && ((st == ST_IDLE && in_offload) || st == ST_CTL);
        ctl_idx  = (st == ST_IDLE) ? 3'd0 : cidx;
        buf_wr   = accept && ((st == ST_IDLE && !in_offload) || st == ST_BODY);
    end

    txck_ctl_parse u_ctl (
        .clk (clk),
        .rst (rst),
        .clr (fr_done),
        .wr  (ctl_wr),
        .idx (ctl_idx),
        .din (in_data),
        .ctl (ctl)
    );

    txck_sum_acc #(.AW(AW)) u_sum (
        .clk      (clk),
        .rst      (rst),
        .clr      (fr_done),
        .en       (buf_wr),
        .pos      (wcnt[AW-1:0]),
        .din      (in_data),
        .l3_off   (ctl.l3_off),
        .l4_off   (ctl.l4_off),
        .udp      (ctl.udp),
        .ph_given (ctl.ph_given),
        .ip_acc   (ip_acc),
        .l4_acc   (l4_acc),
        .hlen     (hlen),
        .totlen   (totlen),
        .frag     (frag)
    );

    txck_frame_buf #(.DEPTH(DEPTH), .AW(AW)) u_buf (
        .clk   (clk),
        .we    (buf_wr),
        .waddr (wcnt[AW-1:0]),
        .wdata (in_data),
        .raddr (rcnt[AW-1:0]),
        .rdata (rd_byte)
    );

    // ---------------- checksum finish ----------------
    always_comb begin
        l4_len  = totlen - {10'd0, hlen};
        l4_all  = l4_acc + {16'd0, (ctl.ph_given ? ctl.ph_sum : l4_len)};
        ip_cs_n = ~fold16(ip_acc);
        l4_raw  = ~fold16(l4_all);
        l4_cs_n = (ctl.udp && l4_raw == 16'd0) ? 16'hFFFF : l4_raw;
    end

    // ---------------- output side ----------------
    always_comb begin
        out_valid = (st == ST_SEND);
        out_last  = out_valid && (rcnt == wcnt - 1'b1);
        fr_done   = out_valid && out_ready && out_last;
        rp        = POS_W'(rcnt);
        ip_pos    = POS_W'(ctl.l3_off) + POS_W'(IP_CS_REL);
        l4_pos    = POS_W'(ctl.l4_off) +
                    (ctl.udp ? POS_W'(UDP_CS_REL) : POS_W'(TCP_CS_REL));
        out_data  = rd_byte;
        if (ip_do && rp == ip_pos)              out_data = ip_cs_q[15:8];
        else if (ip_do && rp == ip_pos + 1'b1)  out_data = ip_cs_q[7:0];
        else if (l4_do && rp == l4_pos)         out_data = l4_cs_q[15:8];
        else if (l4_do && rp == l4_pos + 1'b1)  out_data = l4_cs_q[7:0];
    end

    // ---------------- sequencing ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            cidx    <= '0;
            wcnt    <= '0;
            rcnt    <= '0;
            ip_do   <= 1'b0;
            l4_do   <= 1'b0;
            ip_cs_q <= '0;
            l4_cs_q <= '0;
        end else begin
            case (st)
                ST_IDLE: if (accept) begin
                    if (in_offload) begin
                        cidx <= 3'd1;
                        st   <= ST_CTL;
                    end else begin
                        wcnt <= wcnt + 1'b1;
                        st   <= in_last ? ST_FIN : ST_BODY;
                    end
                end
                ST_CTL: if (accept) begin
                    cidx <= cidx + 1'b1;
                    if (cidx == 3'(CTL_BYTES - 1)) st <= ST_BODY;
                end
                ST_BODY: if (accept) begin
                    wcnt <= wcnt + 1'b1;
                    if (in_last) st <= ST_FIN;
                end
                ST_FIN: begin
                    ip_do   <= ctl.ip_en;
                    l4_do   <= ctl.l4_en && !frag;
                    ip_cs_q <= ip_cs_n;
                    l4_cs_q <= l4_cs_n;
                    rcnt    <= '0;
                    st      <= ST_SEND;
                end
                ST_SEND: if (out_ready) begin
                    if (out_last) begin
                        wcnt  <= '0;
                        rcnt  <= '0;
                        ip_do <= 1'b0;
                        l4_do <= 1'b0;
                        st    <= ST_IDLE;
                    end else begin
                        rcnt <= rcnt + 1'b1;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // R9: no write once the buffer holds DEPTH bytes
    p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
        buf_wr |-> (wcnt < CAP));

    // R9: input and output never open together
    p_one_side_r9: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !in_ready);

    // R10: a stalled output byte holds
    p_out_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

    // R1: output ends right after the last byte of a frame is taken
    p_frame_end_r1: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && out_last) |=> !out_valid);

endmodule

// File: tb/sim_txck_insert.sv
`timescale 1ns/1ps
module sim_txck_insert;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_data = '0;
    logic       in_last = 1'b0;
    logic       in_offload = 1'b0;
    logic       out_valid;
    logic       out_ready = 1'b0;
    logic [7:0] out_data;
    logic       out_last;

    int total = 0;
    int bad   = 0;

    logic [7:0] fr  [0:511];
    logic [7:0] ex  [0:511];
    logic [7:0] got [0:511];
    logic [7:0] cb  [0:7];
    int flen, elen, g_l4len;
    bit g_udp;

    always #2 clk = ~clk;

    txck_insert u0 (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_data    (in_data),
        .in_last    (in_last),
        .in_offload (in_offload),
        .out_valid  (out_valid),
        .out_ready  (out_ready),
        .out_data   (out_data),
        .out_last   (out_last)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] csum(input int start, input int len,
                                         input int skip, input logic [31:0] extra);
        logic [31:0] s;
        logic [7:0]  b;
        s = extra;
        for (int i = 0; i < len; i++) begin
            b = (start + i == skip || start + i == skip + 1) ? 8'h00 : fr[start + i];
            s = s + ((i % 2 == 0) ? {16'd0, b, 8'd0} : {24'd0, b});
        end
        s = (s & 32'hFFFF) + (s >> 16);
        s = (s & 32'hFFFF) + (s >> 16);
        return ~s[15:0];
    endfunction

    // Ethernet-like header of 14 bytes, IPv4 at 14, transport at 34, 3 pad bytes
    task automatic build(input bit udp, input int paylen, input bit frg);
        int l4h;
        int tl;
        l4h = udp ? 8 : 20;
        g_l4len = l4h + paylen;
        g_udp = udp;
        tl = 20 + g_l4len;
        for (int i = 0; i < 14; i++) fr[i] = 8'(i * 7 + 1);
        fr[12] = 8'h08; fr[13] = 8'h00;
        fr[14] = 8'h45; fr[15] = 8'h00; fr[16] = 8'(tl >> 8); fr[17] = 8'(tl);
        fr[18] = 8'h12; fr[19] = 8'h34;
        fr[20] = frg ? 8'h20 : 8'h40; fr[21] = 8'h00;
        fr[22] = 8'h40; fr[23] = udp ? 8'd17 : 8'd6;
        fr[24] = 8'hAB; fr[25] = 8'hCD;
        fr[26] = 8'hC0; fr[27] = 8'hA8; fr[28] = 8'h01; fr[29] = 8'h0A;
        fr[30] = 8'h0A; fr[31] = 8'h00; fr[32] = 8'h00; fr[33] = 8'h05;
        for (int i = 0; i < g_l4len; i++) fr[34 + i] = 8'(i * 13 + 5);
        for (int i = 0; i < 3; i++) fr[34 + g_l4len + i] = 8'hEE;
        flen = 34 + g_l4len + 3;
        for (int i = 0; i < flen; i++) ex[i] = fr[i];
        elen = flen;
    endtask

    task automatic set_cb(input logic [7:0] flags, input logic [15:0] ph);
        cb[0] = flags; cb[1] = 8'h5E; cb[2] = 8'd14; cb[3] = 8'd34;
        cb[4] = 8'h77; cb[5] = 8'h99; cb[6] = ph[15:8]; cb[7] = ph[7:0];
    endtask

    task automatic exp_ip();
        logic [15:0] c;
        c = csum(14, 20, 24, 32'd0);
        ex[24] = c[15:8]; ex[25] = c[7:0];
    endtask

    function automatic logic [15:0] l4_value(input bit use_ph, input logic [15:0] ph);
        logic [31:0] extra;
        logic [15:0] c;
        int cp;
        cp = 34 + (g_udp ? 6 : 16);
        if (use_ph) extra = {16'd0, ph};
        else extra = 32'hC0A8 + 32'h010A + 32'h0A00 + 32'h0005 +
                     (g_udp ? 32'd17 : 32'd6) + 32'(g_l4len);
        c = csum(34, g_l4len, cp, extra);
        if (g_udp && c == 16'd0) c = 16'hFFFF;
        return c;
    endfunction

    task automatic exp_l4(input bit use_ph, input logic [15:0] ph);
        logic [15:0] c;
        int cp;
        cp = 34 + (g_udp ? 6 : 16);
        c = l4_value(use_ph, ph);
        ex[cp] = c[15:8]; ex[cp + 1] = c[7:0];
    endtask

    // sends one frame (offload bit inverted on every later byte, R3) and checks output
    task automatic run_frame(input bit offl, input string req);
        int n, k, mism;
        bit early, done, held, hold_ok, ready_low;
        logic [7:0] hd;
        n = (offl ? 8 : 0) + flen;
        early = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid   = 1'b1;
            in_data    = (offl && i < 8) ? cb[i] : fr[i - (offl ? 8 : 0)];
            in_offload = (i == 0) ? offl : ~offl;
            in_last    = (i == n - 1);
            if (out_valid) early = 1;
            while (!in_ready) @(negedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0; in_offload = 1'b0;
        chk(!early, {req, " R9"}, "output before last input", int'(early), 0);

        k = 0; done = 0; held = 0; hold_ok = 1; ready_low = 1; hd = '0;
        for (int cyc = 0; cyc < 4000 && !done; cyc++) begin
            out_ready = (cyc % 4 != 1);
            if (held) begin
                if (!out_valid || out_data != hd) hold_ok = 0;
                held = 0;
            end
            if (out_valid && in_ready) ready_low = 0;
            if (out_valid && out_ready) begin
                got[k] = out_data;
                k++;
                if (out_last) done = 1;
            end else if (out_valid) begin
                held = 1;
                hd = out_data;
            end
            @(negedge clk);
        end
        out_ready = 1'b0;

        chk(k == elen, req, "frame length", k, elen);
        mism = -1;
        for (int i = 0; i < elen && i < k; i++)
            if (mism < 0 && got[i] != ex[i]) mism = i;
        if (mism >= 0)
            chk(0, req, $sformatf("byte %0d", mism), got[mism], ex[mism]);
        else
            chk(1, req, "bytes", 0, 0);
        chk(hold_ok, "R10", "stalled byte held", int'(hold_ok), 1);
        chk(ready_low, "R9", "in_ready low while sending", int'(!ready_low), 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(in_ready == 1'b1, "R9", "reset in_ready", int'(in_ready), 1);
        chk(out_valid == 1'b0, "R9", "reset out_valid", int'(out_valid), 0);
    endtask

    task automatic t_passthru();           // R2, R3
        build(0, 11, 0);
        run_frame(0, "R2 R3");
    endtask

    task automatic t_tcp();                // R1, R4, R5
        build(0, 37, 0);
        set_cb(8'h03, 16'h0000);
        exp_ip();
        exp_l4(0, 16'h0);
        run_frame(1, "R1 R4 R5");
    endtask

    task automatic t_ip_only();            // R4
        build(0, 6, 0);
        set_cb(8'h01, 16'h0000);
        exp_ip();
        run_frame(1, "R4");
    endtask

    task automatic t_udp();                // R6
        build(1, 9, 0);
        set_cb(8'h07, 16'h0000);
        exp_ip();
        exp_l4(0, 16'h0);
        run_frame(1, "R6");
    endtask

    task automatic t_udp_zero();           // R6: computed zero sent as FFFF
        logic [15:0] c;
        int lw;
        build(1, 20, 0);
        lw = 34 + g_l4len - 2;
        fr[lw] = 8'h00; fr[lw + 1] = 8'h00;
        c = l4_value(0, 16'h0);
        fr[lw] = c[15:8]; fr[lw + 1] = c[7:0];
        for (int i = 0; i < flen; i++) ex[i] = fr[i];
        set_cb(8'h06, 16'h0000);
        exp_l4(0, 16'h0);
        chk(ex[40] == 8'hFF && ex[41] == 8'hFF, "R6", "zero case set up", {ex[40], ex[41]}, 16'hFFFF);
        run_frame(1, "R6 zero");
    endtask

    task automatic t_ph();                 // R7
        build(0, 14, 0);
        set_cb(8'h0B, 16'h5A3C);
        exp_ip();
        exp_l4(1, 16'h5A3C);
        run_frame(1, "R7");
    endtask

    task automatic t_frag();               // R8
        build(0, 10, 1);
        set_cb(8'h03, 16'h0000);
        exp_ip();
        run_frame(1, "R8");
    endtask

    task automatic t_flags_off();          // R11
        build(1, 5, 0);
        set_cb(8'h00, 16'h0000);
        run_frame(1, "R11");
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_passthru();
        t_tcp();
        t_passthru();
        t_ip_only();
        t_udp();
        t_udp_zero();
        t_ph();
        t_frag();
        t_flags_off();
        t_tcp();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R9 watchdog expired act=0 exp=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule